// File: doc/BRIEF.md
# Die Temperature Throttle Monitor

This block watches a die-temperature sensor and asks the CPU clock controller to drop to its lowest operating point or return to its highest one. The sensor is inverted: a smaller count means a hotter die. Two count thresholds form a hysteresis band. A count below the trigger threshold asks for the slow point. A count above the release threshold asks for the fast point. A count inside the band changes nothing.

Both thresholds come from a 32-bit calibration word, which the block loads in the first clock after reset. The word holds two reference counts, one at 25 °C and one at a hot point, plus that hot temperature. The block maps a throttle temperature to a count by linear interpolation between the two reference points. It maps the latest accepted count back to deci-Celsius in the same way. All divisions run one after another on a single multi-cycle divider. A write port changes the throttle temperature, and both thresholds are then recomputed.

Decisions happen only at the end of each check period. A decision that falls due while a conversion is running waits until the conversion has finished.

Top module: `thermal_guard`

## Requirements
- R1: In the first clock after reset the calibration word is split into three fields. Bits 31:20 give the 25 °C count (`room`). Bits 19:8 give the hot-point count (`hot`). Bits 7:0 times 10 give the hot temperature `hv` in deci-Celsius. The default throttle temperature is `hv`−100, clamped at 0.
- R2: A temperature `t` maps to a count by `hot + (S × D) / P`, where:
  - `S` is `room`−`hot`, or 1 if `room` ≤ `hot`;
  - `D` is `hv`−`t`, or 0 if `t` ≥ `hv`;
  - `P` is `hv`−250, or 1 if `hv` ≤ 250.
  The division truncates and the result saturates at 2^CNT_W−1. Once `busy` is low, `trig_cnt` holds the count for the throttle temperature. `rel_cnt` holds the count for the throttle temperature minus 50. `trig_cnt` is never above `rel_cnt`.
- R3: Let `c` be the latest accepted count. When `c` ≥ `hot`, `temp_dc` = `hv` − ((`c`−`hot`) × `P`) / `S`. When `c` < `hot`, `temp_dc` = `hv` + ((`hot`−`c`) × `P`) / `S`. The division truncates and the result saturates to the signed OUT_W range. `temp_dc` reads 0 until the first nonzero count is accepted.
- R4: A sample is accepted only in a cycle where `smp_vld` is 1. Without it, `smp_cnt` changes neither `temp_dc` nor the requests.
- R5: Both requests are 0 after reset. They stay 0 until a nonzero count has been accepted, even if zero-valued valid samples arrive.
- R6: At a decision, a count below `trig_cnt` sets `slow_req` to 1 and `fast_req` to 0.
- R7: At a decision, a count above `rel_cnt` sets `fast_req` to 1 and `slow_req` to 0.
- R8: At a decision, a count from `trig_cnt` to `rel_cnt` inclusive leaves both requests unchanged.
- R9: A decision falls due every CHECK_CYCLES clocks after reset, at the clock edges numbered P, 2P, and so on. A due decision waits while `busy` is 1. Requests change at no other time, and the two requests are never both 1.
- R10: A cycle with `thr_we` at 1 loads `thr_dc` as the throttle temperature. `busy` is 1 in the next cycle and stays 1 until both thresholds are recomputed.
- R11: `busy` is 1 while calibration is loading, while a recompute is pending, while the divider is working, and while an accepted count has not yet been converted. No decision is made while `busy` is 1, and the divider never starts while it is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_word | input | 32 | Calibration word, sampled in the first clock after reset |
| smp_vld | input | 1 | Sensor sample qualifier |
| smp_cnt | input | CNT_W | Sensor count (lower means hotter) |
| thr_we | input | 1 | Throttle temperature write strobe |
| thr_dc | input | TMP_W | New throttle temperature, deci-Celsius |
| slow_req | output | 1 | Request for the lowest operating point (level) |
| fast_req | output | 1 | Request for the highest operating point (level) |
| temp_dc | output | OUT_W | Current temperature, signed deci-Celsius |
| trig_cnt | output | CNT_W | Trigger count in use |
| rel_cnt | output | CNT_W | Release count in use |
| busy | output | 1 | Conversion or recompute in progress |

## Verification
The bench builds the block with 12-bit counts, a 16-bit temperature output and a check period of 200 clocks. This period brings many decision boundaries within a short run, and it lets the bench predict the exact edge at which each decision takes effect. Under several calibrations, including degenerate and saturating ones, the bench converts about one count in eleven across the full 12-bit range. It also sweeps the throttle temperature over its range. It walks the hysteresis band up to and across both of its edges.

// File: rtl/thg_pkg.sv
package thg_pkg;

  typedef enum logic [1:0] {
    JOB_NONE = 2'd0,
    JOB_TRIG = 2'd1,
    JOB_REL  = 2'd2,
    JOB_TEMP = 2'd3
  } job_e;

  // Anchor temperature of the low calibration point, deci-Celsius
  localparam int ANCHOR_DC   = 250;
  // Default throttle point below the hot calibration point
  localparam int DEF_DROP_DC = 100;
  // Release point below the throttle point
  localparam int REL_DROP_DC = 50;
  // Calibration word field positions
  localparam int CAL_ROOM_LSB = 20;
  localparam int CAL_HOT_LSB  = 8;
  localparam int CAL_DEG_MULT = 10;

  function automatic int count_span(input int room, input int hot);
    return (room > hot) ? (room - hot) : 1;
  endfunction

  function automatic int temp_span(input int hv);
    return (hv > ANCHOR_DC) ? (hv - ANCHOR_DC) : 1;
  endfunction

  function automatic int temp_gap(input int hv, input int t);
    return (t < hv) ? (hv - t) : 0;
  endfunction

  function automatic int abs_gap(input int a, input int b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  function automatic int clip(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/thg_divider.sv
module thg_divider #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             run,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] shreg;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CW-1:0]    left;
  logic [DEN_W:0]   rem_sh, rem_nx;
  logic             fits;

  always_comb begin
    rem_sh = {rem_q, shreg[NUM_W-1]};
    fits   = rem_sh >= {1'b0, den_q};
    rem_nx = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      rem_q <= '0;
      den_q <= '0;
      left  <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else if (start) begin
      shreg <= num;
      rem_q <= '0;
      den_q <= den;
      left  <= CW'(NUM_W);
      run   <= 1'b1;
      done  <= 1'b0;
    end else if (run) begin
      shreg <= {shreg[NUM_W-2:0], fits};
      rem_q <= rem_nx[DEN_W-1:0];
      left  <= left - 1'b1;
      if (left == CW'(1)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quo = shreg;
endmodule

// File: rtl/thg_tick.sv
module thg_tick #(
  parameter int PERIOD = 2400000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [TW-1:0] cnt;

  assign tick = (cnt == TW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/thg_decide.sv
module thg_decide #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             busy,
  input  logic             armed,
  input  logic [CNT_W-1:0] last_cnt,
  input  logic [CNT_W-1:0] trig_cnt,
  input  logic [CNT_W-1:0] rel_cnt,
  output logic             fire,
  output logic             slow_req,
  output logic             fast_req
);
  logic owed, want;

  assign want = tick | owed;
  assign fire = want & ~busy & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed     <= 1'b0;
      slow_req <= 1'b0;
      fast_req <= 1'b0;
    end else begin
      owed <= want & busy;
      if (fire) begin
        if (last_cnt < trig_cnt) begin
          slow_req <= 1'b1;
          fast_req <= 1'b0;
        end else if (last_cnt > rel_cnt) begin
          slow_req <= 1'b0;
          fast_req <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thg_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int TMP_W        = 12,
  parameter int OUT_W        = 16,
  parameter int CHECK_CYCLES = 2400000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [31:0]             cal_word,
  input  logic                    smp_vld,
  input  logic [CNT_W-1:0]        smp_cnt,
  input  logic                    thr_we,
  input  logic [TMP_W-1:0]        thr_dc,
  output logic                    slow_req,
  output logic                    fast_req,
  output logic signed [OUT_W-1:0] temp_dc,
  output logic [CNT_W-1:0]        trig_cnt,
  output logic [CNT_W-1:0]        rel_cnt,
  output logic                    busy
);
  localparam int NUM_W   = CNT_W + TMP_W + 1;
  localparam int DEN_W   = (TMP_W > CNT_W) ? TMP_W : CNT_W;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int TMP_MAX = (1 << TMP_W) - 1;
  localparam int OUT_MAX = (1 << (OUT_W - 1)) - 1;
  localparam int OUT_MIN = -(1 << (OUT_W - 1));

  logic             ld_done, armed, tsign;
  logic             pend_trig, pend_rel;
  logic [CNT_W-1:0] room_q, hot_q, last_cnt, cvt_cnt;
  logic [TMP_W-1:0] hv_q, thr_q;
  job_e             cur_job, next_job;

  logic             div_start, div_run, div_done;
  logic [NUM_W-1:0] div_num, div_quo;
  logic [DEN_W-1:0] div_den;
  logic             tick, decide_now;

  int cspan_i, tspan_i, hv_i, hot_i, quo_i;

  // Job selection and divider operands
  always_comb begin
    hv_i    = int'(hv_q);
    hot_i   = int'(hot_q);
    quo_i   = int'(div_quo);
    cspan_i = count_span(int'(room_q), hot_i);
    tspan_i = temp_span(hv_i);

    next_job = JOB_NONE;
    if (ld_done && cur_job == JOB_NONE) begin
      if (pend_trig)                        next_job = JOB_TRIG;
      else if (pend_rel)                    next_job = JOB_REL;
      else if (armed && last_cnt != cvt_cnt) next_job = JOB_TEMP;
    end
    div_start = (next_job != JOB_NONE);

    div_num = '0;
    div_den = DEN_W'(1);
    case (next_job)
      JOB_TRIG: begin
        div_num = NUM_W'(cspan_i * temp_gap(hv_i, int'(thr_q)));
        div_den = DEN_W'(tspan_i);
      end
      JOB_REL: begin
        div_num = NUM_W'(cspan_i * temp_gap(hv_i, int'(thr_q) - REL_DROP_DC));
        div_den = DEN_W'(tspan_i);
      end
      JOB_TEMP: begin
        div_num = NUM_W'(abs_gap(int'(last_cnt), hot_i) * tspan_i);
        div_den = DEN_W'(cspan_i);
      end
      default: ;
    endcase
  end

  assign busy = ~ld_done | pend_trig | pend_rel | (cur_job != JOB_NONE)
              | (armed & (last_cnt != cvt_cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_done   <= 1'b0;
      armed     <= 1'b0;
      tsign     <= 1'b0;
      pend_trig <= 1'b0;
      pend_rel  <= 1'b0;
      room_q    <= '0;
      hot_q     <= '0;
      hv_q      <= '0;
      thr_q     <= '0;
      last_cnt  <= '0;
      cvt_cnt   <= '0;
      cur_job   <= JOB_NONE;
      trig_cnt  <= '0;
      rel_cnt   <= '0;
      temp_dc   <= '0;
    end else begin
      if (!ld_done) begin
        room_q    <= CNT_W'(cal_word[31:CAL_ROOM_LSB]);
        hot_q     <= CNT_W'(cal_word[CAL_ROOM_LSB-1:CAL_HOT_LSB]);
        hv_q      <= TMP_W'(int'(cal_word[CAL_HOT_LSB-1:0]) * CAL_DEG_MULT);
        thr_q     <= TMP_W'(clip(int'(cal_word[CAL_HOT_LSB-1:0]) * CAL_DEG_MULT
                                 - DEF_DROP_DC, 0, TMP_MAX));
        pend_trig <= 1'b1;
        pend_rel  <= 1'b1;
        ld_done   <= 1'b1;
      end

      if (smp_vld) begin
        last_cnt <= smp_cnt;
        if (smp_cnt != '0) armed <= 1'b1;
      end

      if (div_start) begin
        cur_job <= next_job;
        case (next_job)
          JOB_TRIG: pend_trig <= 1'b0;
          JOB_REL:  pend_rel  <= 1'b0;
          JOB_TEMP: begin
            cvt_cnt <= last_cnt;
            tsign   <= (last_cnt < hot_q);
          end
          default: ;
        endcase
      end

      if (div_done) begin
        case (cur_job)
          JOB_TRIG: trig_cnt <= CNT_W'(clip(quo_i + hot_i, 0, CNT_MAX));
          JOB_REL:  rel_cnt  <= CNT_W'(clip(quo_i + hot_i, 0, CNT_MAX));
          JOB_TEMP: temp_dc  <= OUT_W'(clip(tsign ? (hv_i + quo_i) : (hv_i - quo_i),
                                            OUT_MIN, OUT_MAX));
          default: ;
        endcase
        cur_job <= JOB_NONE;
      end

      if (thr_we) begin
        thr_q     <= thr_dc;
        pend_trig <= 1'b1;
        pend_rel  <= 1'b1;
      end
    end
  end

  thg_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .run   (div_run),
    .done  (div_done),
    .quo   (div_quo)
  );

  thg_tick #(.PERIOD(CHECK_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  thg_decide #(.CNT_W(CNT_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .busy     (busy),
    .armed    (armed),
    .last_cnt (last_cnt),
    .trig_cnt (trig_cnt),
    .rel_cnt  (rel_cnt),
    .fire     (decide_now),
    .slow_req (slow_req),
    .fast_req (fast_req)
  );
endmodule

// File: rtl/thg_chk.sv
module thg_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slow_req,
  input logic             fast_req,
  input logic             busy,
  input logic             decide_now,
  input logic             armed,
  input logic             thr_we,
  input logic             div_start,
  input logic             div_run,
  input logic [CNT_W-1:0] trig_cnt,
  input logic [CNT_W-1:0] rel_cnt
);
  // R9
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(slow_req && fast_req));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !decide_now |=> ($stable(slow_req) && $stable(fast_req)));

  // R5
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!slow_req && !fast_req));

  // R11
  decide_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decide_now |-> !busy);

  // R10
  write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_we |=> busy);

  // R2
  band_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (trig_cnt <= rel_cnt));

  // R11
  div_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> !div_run);
endmodule

bind thermal_guard thg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slow_req   (slow_req),
  .fast_req   (fast_req),
  .busy       (busy),
  .decide_now (decide_now),
  .armed      (armed),
  .thr_we     (thr_we),
  .div_start  (div_start),
  .div_run    (div_run),
  .trig_cnt   (trig_cnt),
  .rel_cnt    (rel_cnt)
);

// File: tb/thermal_guard_test.sv
module thermal_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 200;
  localparam int CW = 12;
  localparam int TW = 12;
  localparam int OW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   cal_word = '0;
  logic          smp_vld = 1'b0;
  logic [CW-1:0] smp_cnt = '0;
  logic          thr_we = 1'b0;
  logic [TW-1:0] thr_dc = '0;
  logic          slow_req, fast_req, busy;
  logic signed [OW-1:0] temp_dc;
  logic [CW-1:0] trig_cnt, rel_cnt;

  thermal_guard #(.CNT_W(CW), .TMP_W(TW), .OUT_W(OW), .CHECK_CYCLES(PER)) uut (
    .clk(clk), .rst_n(rst_n), .cal_word(cal_word), .smp_vld(smp_vld),
    .smp_cnt(smp_cnt), .thr_we(thr_we), .thr_dc(thr_dc),
    .slow_req(slow_req), .fast_req(fast_req), .temp_dc(temp_dc),
    .trig_cnt(trig_cnt), .rel_cnt(rel_cnt), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int ecnt;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;

  int n_chk = 0;
  int n_bad = 0;
  int m_room, m_hot, m_hv, m_thr;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // bench model: interpolation restated with long integers
  function automatic int f_cnt(input int t);
    longint ds, ts, gap, r;
    ds  = (m_room <= m_hot) ? 1 : m_room - m_hot;
    ts  = (m_hv <= 250) ? 1 : m_hv - 250;
    gap = (t >= m_hv) ? 0 : m_hv - t;
    r   = m_hot + (ds * gap) / ts;
    if (r > 4095) r = 4095;
    return int'(r);
  endfunction

  function automatic int f_temp(input int c);
    longint ds, ts, step, r;
    ds = (m_room <= m_hot) ? 1 : m_room - m_hot;
    ts = (m_hv <= 250) ? 1 : m_hv - 250;
    if (c < m_hot) begin
      step = ((m_hot - c) * ts) / ds;
      r = m_hv + step;
    end else begin
      step = ((c - m_hot) * ts) / ds;
      r = m_hv - step;
    end
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic settle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic load(input int room, input int hot, input int deg);
    cal_word = {room[11:0], hot[11:0], deg[7:0]};
    m_room = room; m_hot = hot; m_hv = deg * 10;
    m_thr = (m_hv > 100) ? m_hv - 100 : 0;
    smp_vld = 1'b0; thr_we = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 reset slow_req", int'(slow_req), 0);
    chk("R5 reset fast_req", int'(fast_req), 0);
    chk("R3 reset temp_dc", int'(temp_dc), 0);
    rst_n = 1'b1;
    settle();
    chk("R1 default trig_cnt", int'(trig_cnt), f_cnt(m_thr));
    chk("R1 default rel_cnt", int'(rel_cnt), f_cnt(m_thr - 50));
  endtask

  task automatic sample(input int c, input bit v);
    smp_cnt = c[CW-1:0];
    smp_vld = v;
    @(negedge clk);
    smp_vld = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic to_fire();
    while ((ecnt % PER) != PER - 1) @(negedge clk);
  endtask

  task automatic decide(input int c, input int es, input int ef, input string tag);
    int ps, pf;
    to_fire();
    ps = int'(slow_req); pf = int'(fast_req);
    smp_cnt = c[CW-1:0]; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    while (busy) @(negedge clk);
    to_fire();
    chk("R9 hold until check slow_req", int'(slow_req), ps);
    chk("R9 hold until check fast_req", int'(fast_req), pf);
    @(negedge clk);
    chk({tag, " slow_req"}, int'(slow_req), es);
    chk({tag, " fast_req"}, int'(fast_req), ef);
  endtask

  task automatic write_thr(input int t);
    thr_dc = t[TW-1:0]; thr_we = 1'b1;
    @(negedge clk);
    thr_we = 1'b0;
    chk("R10 busy after write", int'(busy), 1);
    m_thr = t;
    while (busy) @(negedge clk);
    chk("R10 R2 trig_cnt", int'(trig_cnt), f_cnt(t));
    chk("R10 R2 rel_cnt", int'(rel_cnt), f_cnt(t - 50));
  endtask

  task automatic sweep_temp();
    for (int c = 1; c < 4096; c += 11) begin
      sample(c, 1'b1);
      chk("R3 temp sweep", int'(temp_dc), f_temp(c));
    end
    sample(4095, 1'b1);
    chk("R3 temp top count", int'(temp_dc), f_temp(4095));
    sample(m_hot, 1'b1);
    chk("R3 temp at hot point", int'(temp_dc), m_hv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int tc, rc, keep;
    // calibration A
    load(1400, 1100, 105);
    tc = int'(trig_cnt); rc = int'(rel_cnt);
    decide(0, 0, 0, "R5 zero sample unarmed");
    chk("R3 temp stays zero before arming", int'(temp_dc), 0);
    decide(rc + 5, 0, 1, "R7 cool");
    decide((tc + rc) / 2, 0, 1, "R8 inside band after cool");
    decide(tc - 1, 1, 0, "R6 hot");
    decide(tc, 1, 0, "R8 at trigger edge");
    decide(rc, 1, 0, "R8 at release edge");
    decide(rc + 1, 0, 1, "R7 just past release");
    decide(tc, 0, 1, "R8 trigger edge after cool");
    // R4: invalid sample ignored
    keep = int'(temp_dc);
    sample(tc - 50, 1'b0);
    chk("R4 invalid sample temp_dc", int'(temp_dc), keep);
    to_fire();
    @(negedge clk);
    chk("R4 invalid sample slow_req", int'(slow_req), 0);
    chk("R4 invalid sample fast_req", int'(fast_req), 1);
    for (int t = 0; t <= 1400; t += 37) write_thr(t);
    write_thr(4000);
    chk("R2 above hot point gives hot count", int'(trig_cnt), m_hot);
    write_thr(1000);
    decide(int'(trig_cnt) - 1, 1, 0, "R10 R6 new threshold in use");
    sweep_temp();
    // degenerate calibration B
    load(500, 500, 20);
    sweep_temp();
    // calibration C
    load(3000, 2000, 90);
    sweep_temp();
    // calibration D: threshold count saturates
    load(4000, 3900, 30);
    write_thr(0);
    chk("R2 saturated trig_cnt", int'(trig_cnt), 4095);
    // calibration E: temperature saturates
    load(1001, 1000, 255);
    sample(4095, 1'b1);
    chk("R3 low saturation", int'(temp_dc), -32768);
    sample(1, 1'b1);
    chk("R3 high saturation", int'(temp_dc), 32767);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule